// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Interface

This block is the digital front end of a converter with two channels and 12-bit codes. A host writes each channel's code in two byte writes on an 8-bit parallel bus. Each write uses an active-low chip select, an active-low write strobe and a 2-bit address. The bytes go into per-channel input registers. A separate active-low load strobe later copies both channels' input registers into their output code registers in the same clock cycle. The host can therefore prepare both channels in any order and switch them together.

All strobes are asynchronous to the system clock. Each one passes through a synchronizer before the edge detection. A write is committed when the write cycle ends. The output codes are captured when the load strobe returns high, and only if the strobe was low for at least `MIN_LOW` clocks, counted from the later of its falling edge and the end of any overlapping write. A load that is too short leaves the output codes unchanged and raises an error flag.

For each channel the block also gives a scaled unipolar level: floor(vin·D/4096) for output code D.

Top module: `dual_dac_loader`

## Requirements
- R1: A synchronous active-high `rst` clears both input registers and both output codes to 0 and clears `loadErr`.
- R2: A byte is stored only when `csN` and `wrN` are both low (both are active low). A write strobe pulse while `csN` is high stores nothing.
- R3: The address picks the target. 0 is channel A code bits [7:0], 1 is channel A bits [11:8], 2 is channel B bits [7:0], and 3 is channel B bits [11:8].
- R4: A write to an upper part (address 1 or 3) keeps only `dataIn[3:0]`. Bits [7:4] have no effect on the code.
- R5: While `loadN` stays high, writes to the input registers, in any order, leave `dacA` and `dacB` unchanged.
- R6: A low pulse on `loadN` that lasts at least `MIN_LOW` clocks copies the full 12-bit input contents of both channels into `dacA` and `dacB` together when `loadN` returns high.
- R7: After `loadN` returns high, the output codes hold their value until the next valid load, even if later writes change the input registers.
- R8: A load pulse shorter than `MIN_LOW` clocks leaves both output codes unchanged and sets `loadErr`. The next valid load clears `loadErr`.
- R9: If a write ends while `loadN` is low, the low-time count restarts at the end of that write. A release fewer than `MIN_LOW` clocks later is treated as a short load (R8).
- R10: `voutA` and `voutB` equal floor(vin·D/4096) for their channel's code D. Code 0xFFF gives 4095/4096 of vin, 0x800 gives half of vin, and 0x000 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Target register select |
| dataIn | input | 8 | Right-justified write data |
| loadN | input | 1 | Load strobe, active low, asynchronous |
| vin | input | VIN_W | Reference level used for scaling |
| dacA | output | 12 | Channel A output code |
| dacB | output | 12 | Channel B output code |
| voutA | output | VIN_W | Scaled level for channel A |
| voutB | output | VIN_W | Scaled level for channel B |
| loadErr | output | 1 | Set by a short or overlapping load |

## Verification
A vector table interleaves byte writes to all four addresses in a mixed order with occasional loads. Steps without a load show that writes never reach the output codes. Steps with a load show that both channels move together and that every byte landed in the right channel and part. High-nibble writes carry set upper bits, so any leak of bits [7:4] shows up. Directed cases separate a write with chip select high or write strobe high, a load that is too short, and a load that straddles a write and is released too early and then late enough. Codes 0x000, 0x800 and 0xFFF check the scaling end points.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int CODE_W = 12;
  localparam int LOW_W  = 8;
  localparam int HIGH_W = CODE_W - LOW_W;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic             commit;
    logic             chanSel;
    logic             highPart;
    logic [LOW_W-1:0] byteVal;
    logic             transfer;
  } dacStrobe_t;
endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageReg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stageReg[s] <= '1;
        else if (s == 0) stageReg[s] <= asyncIn;
        else stageReg[s] <= stageReg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageReg[STAGES-1];
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int MIN_LOW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csS,
  input  logic             wrS,
  input  logic             loadS,
  input  logic [1:0]       addrIn,
  input  logic [LOW_W-1:0] dataIn,
  output dacStrobe_t       strobe,
  output logic             loadErr
);
  localparam int CNT_W = $clog2(MIN_LOW + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW);

  logic             wrActive, wrPrev, writeEnd;
  logic             loadPrev, loadRise, loadOk;
  logic [1:0]       holdAddr;
  logic [LOW_W-1:0] holdData;
  logic [CNT_W-1:0] lowCnt;

  assign wrActive = ~csS & ~wrS;
  assign writeEnd = wrPrev & ~wrActive;
  assign loadRise = loadS & ~loadPrev;
  assign loadOk   = (lowCnt >= MIN_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev   <= 1'b0;
      loadPrev <= 1'b1;
      holdAddr <= '0;
      holdData <= '0;
      lowCnt   <= '0;
      loadErr  <= 1'b0;
    end else begin
      wrPrev   <= wrActive;
      loadPrev <= loadS;
      if (wrActive) begin
        holdAddr <= addrIn;
        holdData <= dataIn;
      end
      if (loadS) lowCnt <= '0;
      else if (writeEnd) lowCnt <= '0;
      else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
      if (loadRise) loadErr <= ~loadOk;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.commit   = writeEnd;
    strobe.chanSel  = holdAddr[1];
    strobe.highPart = holdAddr[0];
    strobe.byteVal  = holdData;
    strobe.transfer = loadRise & loadOk;
  end
endmodule

// File: rtl/dac_load_dpath.sv
module dac_load_dpath
  import dac_load_pkg::*;
#(
  parameter int VIN_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  dacStrobe_t                       strobe,
  input  logic [VIN_W-1:0]                 vin,
  output logic [NUM_CH-1:0][CODE_W-1:0]    dacCode,
  output logic [NUM_CH-1:0][VIN_W-1:0]     scaled
);
  localparam int PROD_W = VIN_W + CODE_W;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [LOW_W-1:0]  inLow;
      logic [HIGH_W-1:0] inHigh;
      logic [CODE_W-1:0] outReg;
      logic [PROD_W-1:0] prod;
      logic              hit;

      assign hit = strobe.commit && (strobe.chanSel == 1'(ch));

      always_ff @(posedge clk) begin
        if (rst) begin
          inLow  <= '0;
          inHigh <= '0;
          outReg <= '0;
        end else begin
          if (hit && strobe.highPart)  inHigh <= strobe.byteVal[HIGH_W-1:0];
          if (hit && !strobe.highPart) inLow  <= strobe.byteVal;
          if (strobe.transfer)         outReg <= {inHigh, inLow};
        end
      end

      assign prod        = {{CODE_W{1'b0}}, vin} * {{VIN_W{1'b0}}, outReg};
      assign dacCode[ch] = outReg;
      assign scaled[ch]  = prod[PROD_W-1:CODE_W];
    end
  endgenerate
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_load_pkg::*;
#(
  parameter int VIN_W       = 8,
  parameter int MIN_LOW     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [7:0]        dataIn,
  input  logic              loadN,
  input  logic [VIN_W-1:0]  vin,
  output logic [11:0]       dacA,
  output logic [11:0]       dacB,
  output logic [VIN_W-1:0]  voutA,
  output logic [VIN_W-1:0]  voutB,
  output logic              loadErr
);
  logic [2:0] syncBus;
  dacStrobe_t strobe;
  logic [NUM_CH-1:0][CODE_W-1:0] dacCode;
  logic [NUM_CH-1:0][VIN_W-1:0]  scaled;

  dac_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst(rst),
    .asyncIn({csN, wrN, loadN}),
    .syncOut(syncBus)
  );

  dac_load_ctrl #(.MIN_LOW(MIN_LOW)) u_ctrl (
    .clk(clk), .rst(rst),
    .csS(syncBus[2]), .wrS(syncBus[1]), .loadS(syncBus[0]),
    .addrIn(addr), .dataIn(dataIn),
    .strobe(strobe), .loadErr(loadErr)
  );

  dac_load_dpath #(.VIN_W(VIN_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .vin(vin),
    .dacCode(dacCode), .scaled(scaled)
  );

  assign dacA  = dacCode[0];
  assign dacB  = dacCode[1];
  assign voutA = scaled[0];
  assign voutB = scaled[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int VIN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             loadN,
  input logic [VIN_W-1:0] vin,
  input logic [11:0]      dacA,
  input logic [11:0]      dacB,
  input logic [VIN_W-1:0] voutA,
  input logic [VIN_W-1:0] voutB,
  input logic             loadErr
);
  localparam int EW = VIN_W + 13;
  logic [EW-1:0] fullA, fullB, floorA, floorB, ceilA, ceilB;

  always_comb begin
    fullA  = EW'(vin) * EW'(dacA);
    fullB  = EW'(vin) * EW'(dacB);
    floorA = EW'(voutA) << 12;
    floorB = EW'(voutB) << 12;
    ceilA  = (EW'(voutA) + 1'b1) << 12;
    ceilB  = (EW'(voutB) + 1'b1) << 12;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dacA == 12'h000 && dacB == 12'h000 && !loadErr));

  assert_hold_while_high_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable({dacA, dacB}) |-> ($past(loadN, 1) && $past(loadN, 2)));

  assert_short_no_update_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(loadErr) |-> $stable({dacA, dacB}));

  assert_scale_bounds_R10: assert property (@(posedge clk) disable iff (rst)
    (floorA <= fullA) && (fullA < ceilA) && (floorB <= fullB) && (fullB < ceilB));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.VIN_W(VIN_W)) u_chk (.*);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
  localparam int VIN_W = 8;
  localparam int NVEC  = 8;
  // fields: addr[34:33] data[32:25] doLoad[24] expA[23:12] expB[11:0]
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd0, 8'h5A, 1'b0, 12'h000, 12'h000},
    {2'd1, 8'hF3, 1'b0, 12'h000, 12'h000},
    {2'd3, 8'h07, 1'b0, 12'h000, 12'h000},
    {2'd2, 8'hC1, 1'b1, 12'h35A, 12'h7C1},
    {2'd1, 8'h08, 1'b0, 12'h35A, 12'h7C1},
    {2'd0, 8'h00, 1'b1, 12'h800, 12'h7C1},
    {2'd3, 8'hFF, 1'b0, 12'h800, 12'h7C1},
    {2'd2, 8'hFF, 1'b1, 12'h800, 12'hFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, wrN = 1'b1, loadN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [VIN_W-1:0] vin = 8'd200;
  logic [11:0] dacA, dacB;
  logic [VIN_W-1:0] voutA, voutB;
  logic loadErr;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_dac_loader #(.VIN_W(VIN_W), .MIN_LOW(4), .SYNC_STAGES(2)) u_dual_dac_loader (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .addr(addr), .dataIn(dataIn),
    .loadN(loadN), .vin(vin), .dacA(dacA), .dacB(dacB),
    .voutA(voutA), .voutB(voutB), .loadErr(loadErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] scale(input logic [11:0] code, input logic [7:0] v);
    return (32'(v) * 32'(code)) / 4096;
  endfunction

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic csVal, input logic wrVal);
    @(negedge clk);
    addr = a; dataIn = d; csN = csVal; wrN = wrVal;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic loadPulse(input int n);
    @(negedge clk);
    loadN = 1'b0;
    repeat (n) @(negedge clk);
    loadN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dacA", dacA, 0);
    chk("R1 dacB", dacB, 0);
    chk("R1 loadErr", loadErr, 0);
    chk("R10 zero code", voutA, 0);

    // table: R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][34:33], VEC[i][32:25], 1'b0, 1'b0);
      if (VEC[i][24]) loadPulse(8);
      chk($sformatf("R3/R4/R5/R6 step%0d dacA", i), dacA, VEC[i][23:12]);
      chk($sformatf("R3/R4/R5/R6 step%0d dacB", i), dacB, VEC[i][11:0]);
      chk($sformatf("R10 step%0d voutA", i), voutA, scale(VEC[i][23:12], vin));
      chk($sformatf("R10 step%0d voutB", i), voutB, scale(VEC[i][11:0], vin));
    end

    // R10 end points with full vin
    vin = 8'd255;
    @(negedge clk);
    chk("R10 full scale", voutB, 32'd254);
    chk("R10 half scale", voutA, 32'd127);

    // R2: chip select high, then write strobe high; input A low stays 00
    busWrite(2'd0, 8'h77, 1'b1, 1'b0);
    busWrite(2'd0, 8'h66, 1'b0, 1'b1);
    loadPulse(8);
    chk("R2 dacA unchanged", dacA, 12'h800);

    // R7: write while load high after a load, outputs hold
    busWrite(2'd2, 8'h12, 1'b0, 1'b0);
    chk("R7 dacB held", dacB, 12'hFFF);

    // R8 short load
    loadPulse(2);
    chk("R8 dacB not updated", dacB, 12'hFFF);
    chk("R8 error set", loadErr, 1);
    loadPulse(8);
    chk("R8 valid load updates", dacB, 12'hF12);
    chk("R8 error cleared", loadErr, 0);

    // R9 overlap released too soon after write end
    @(negedge clk);
    loadN = 1'b0;
    repeat (6) @(negedge clk);
    addr = 2'd0; dataIn = 8'h34; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    repeat (2) @(negedge clk);
    loadN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 early release no update", dacA, 12'h800);
    chk("R9 early release error", loadErr, 1);

    // R9 overlap held long enough
    @(negedge clk);
    loadN = 1'b0;
    repeat (6) @(negedge clk);
    addr = 2'd1; dataIn = 8'h05; csN = 1'b0; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    repeat (8) @(negedge clk);
    loadN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 late release update", dacA, 12'h534);
    chk("R9 late release error clear", loadErr, 0);

    // R1 reset from loaded state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dacA after reset", dacA, 0);
    chk("R1 dacB after reset", dacB, 0);
    loadPulse(8);
    chk("R1 input regs cleared", dacB, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule